// File: doc/BRIEF.md
# UART Receive FIFO with Trigger and Timeout

This block holds the bytes received by a UART until software reads them. It stores up to 16 bytes in arrival order. A received byte enters on a one-cycle push strobe. A strobe on the data-register read pops the oldest byte. The block also keeps the receive control, channel-mode and trigger-level registers. From these it gates pushes and pops, carries out a self-clearing soft flush, and picks where bytes come from.

The interrupt unit receives the level status outputs (empty, full, at-or-above-trigger) and two one-cycle event pulses. One pulse marks a byte dropped on overrun. The other marks a receive gap timeout: no byte has been accepted for four character times since the last accepted byte. The character time is an input given in clock ticks.

Top module: `uart_rx_fifo`

## Requirements
- R1: The FIFO holds up to 16 bytes and returns them oldest first. `empty_o` is high exactly when it holds none, and `full_o` is high exactly when it holds 16.
- R2: A push accepted by the gating while 16 bytes are held drops the byte. A pop in the same cycle does not free a slot for it, because fullness is judged before the pop. `overrun_o` is then high for exactly the one cycle after that clock edge.
- R3: `trig_o` is high whenever the byte count is greater than or equal to the 6-bit trigger level, and low otherwise. The level resets to 32, so `trig_o` is low after reset, and a level of 0 holds `trig_o` high even when the FIFO is empty.
- R4: `rd_data_o` shows the oldest byte when receive is enabled and the FIFO is not empty; otherwise it shows 0. A read of an empty FIFO changes nothing and leaves `empty_o` high.
- R5: Receive is enabled only when control bit 2 is 1 and control bit 3 is 0. While receive is disabled, pushes and pops have no effect.
- R6: Each byte actually stored loads a gap timer with 4 × `char_time_i`. If no further byte is stored, `timeout_o` pulses for one cycle after exactly 4 × `char_time_i` clock edges. The timer then stays idle until the next stored byte.
- R7: Writing control bit 0 as 1 leaves that bit set for one cycle. On the next edge the FIFO is emptied, the gap timer is stopped and bit 0 clears itself; a push or pop in that cycle is discarded.
- R8: The channel mode is mode bits [9:8]: 00 normal, 01 echo, 10 local loopback, 11 remote loopback. In 00 and 01 line bytes are pushed. In 10 data-register writes are pushed and line bytes are not. In 11 neither is pushed.
- R9: After reset the control register reads 0x128 (receive disabled), the mode is normal and the FIFO is empty.
- R10: A pop from a full FIFO clears `full_o`, and popping the last byte sets `empty_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 9 | Control write value: bit 0 flush, bit 2 enable, bit 3 disable |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 10 | Mode write value; bits [9:8] are the channel mode |
| trig_wr_i | input | 1 | Trigger level write strobe |
| trig_wdata_i | input | 6 | Trigger level |
| char_time_i | input | 16 | One character time in clock ticks |
| line_push_i | input | 1 | Byte received from the line |
| line_data_i | input | 8 | Received line byte |
| dr_wr_i | input | 1 | Data register write strobe |
| dr_wdata_i | input | 8 | Data register write byte |
| dr_rd_i | input | 1 | Data register read strobe (pop) |
| rd_data_o | output | 8 | Byte presented for reading |
| ctrl_o | output | 9 | Control register value |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |
| trig_o | output | 1 | Count at or above trigger level |
| overrun_o | output | 1 | Byte dropped on full FIFO (pulse) |
| timeout_o | output | 1 | Receive gap timeout (pulse) |

## Verification
The FIFO is exercised in three ways:
- It is filled one byte at a time to full and then pushed once more. This separates correct dropping from overwriting.
- A push and a pop are issued together on a full FIFO. This shows whether fullness is judged before or after the pop.
- It is drained past empty. This separates the zero return from a stale byte.

Each channel mode is given both a line byte and a data-register write, which shows which source each mode accepts. Pushes and pops are also issued with receive disabled, and a flush is issued with data stored. A behavioural model of these rules is compared against every output on every cycle, so an early or late status change or pulse shows up as a mismatch.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
  typedef enum logic [1:0] {
    CHM_NORMAL = 2'b00,
    CHM_ECHO   = 2'b01,
    CHM_LOCAL  = 2'b10,
    CHM_REMOTE = 2'b11
  } chan_mode_e;

  localparam int CTRL_W    = 9;
  localparam int MODE_W    = 10;
  localparam int MODE_LSB  = 8;
  localparam int BIT_FLUSH = 0;
  localparam int BIT_RXEN  = 2;
  localparam int BIT_RXDIS = 3;
  localparam logic [CTRL_W-1:0] CTRL_RST = 9'h128;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_fifo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TRIG_W   = 6,
  parameter int TRIG_RST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              trig_wr_i,
  input  logic [TRIG_W-1:0] trig_wdata_i,
  input  logic              line_push_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              dr_wr_i,
  input  logic [DATA_W-1:0] dr_wdata_i,
  input  logic              dr_rd_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [TRIG_W-1:0] trig_lvl_o,
  output logic              rx_en_o,
  output logic              flush_o,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              pop_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [TRIG_W-1:0] trig_q;
  chan_mode_e        mode_q;
  logic              src_push;
  logic [DATA_W-1:0] src_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      trig_q <= TRIG_W'(TRIG_RST);
      mode_q <= CHM_NORMAL;
    end else begin
      if (ctrl_wr_i) ctrl_q <= ctrl_wdata_i;
      else if (ctrl_q[BIT_FLUSH]) ctrl_q[BIT_FLUSH] <= 1'b0;
      if (trig_wr_i) trig_q <= trig_wdata_i;
      if (mode_wr_i) mode_q <= chan_mode_e'(mode_wdata_i[MODE_LSB+1:MODE_LSB]);
    end
  end

  always_comb begin
    src_push = 1'b0;
    src_data = line_data_i;
    unique case (mode_q)
      CHM_NORMAL, CHM_ECHO: src_push = line_push_i;
      CHM_LOCAL: begin
        src_push = dr_wr_i;
        src_data = dr_wdata_i;
      end
      default: src_push = 1'b0;  // remote loopback bypasses the FIFO
    endcase
  end

  assign rx_en_o     = ctrl_q[BIT_RXEN] & ~ctrl_q[BIT_RXDIS];
  assign flush_o     = ctrl_q[BIT_FLUSH];
  assign push_o      = rx_en_o & src_push;
  assign push_data_o = src_data;
  assign pop_o       = rx_en_o & dr_rd_i;
  assign ctrl_o      = ctrl_q;
  assign trig_lvl_o  = trig_q;
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              stored_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovr_q, full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i & ~full & ~flush_i;
  assign do_pop  = pop_i & (cnt_q != '0) & ~flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      ovr_q <= push_i & full;  // full is judged before a same-cycle pop
    end
  end

  assign head_o    = (cnt_q != '0) ? mem_q[rd_q] : '0;
  assign count_o   = cnt_q;
  assign stored_o  = do_push;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int CT_W = 16,
  localparam int TMR_W = CT_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            load_i,
  input  logic [CT_W-1:0] char_time_i,
  output logic            timeout_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             armed_q, tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      if (flush_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (load_i) begin
        cnt_q   <= {char_time_i, 2'b00};  // four character times
        armed_q <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q <= TMR_W'(1)) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
          tmo_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign timeout_o = tmo_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter int TRIG_W   = 6,
  parameter int TRIG_RST = 32,
  parameter int CT_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              trig_wr_i,
  input  logic [TRIG_W-1:0] trig_wdata_i,
  input  logic [CT_W-1:0]   char_time_i,
  input  logic              line_push_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              dr_wr_i,
  input  logic [DATA_W-1:0] dr_wdata_i,
  input  logic              dr_rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              trig_o,
  output logic              overrun_o,
  output logic              timeout_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TRIG_W-1:0] trig_lvl;
  logic              rx_en, flush, push, pop, stored;
  logic [DATA_W-1:0] push_data, head;
  logic [CNT_W-1:0]  count;

  uart_rx_ctrl #(.DATA_W(DATA_W), .TRIG_W(TRIG_W), .TRIG_RST(TRIG_RST)) u_ctrl (
    .clk_i, .rst_ni, .ctrl_wr_i, .ctrl_wdata_i, .mode_wr_i, .mode_wdata_i,
    .trig_wr_i, .trig_wdata_i, .line_push_i, .line_data_i, .dr_wr_i,
    .dr_wdata_i, .dr_rd_i, .ctrl_o, .trig_lvl_o(trig_lvl), .rx_en_o(rx_en),
    .flush_o(flush), .push_o(push), .push_data_o(push_data), .pop_o(pop)
  );

  uart_rx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(push), .push_data_i(push_data),
    .pop_i(pop), .head_o(head), .count_o(count), .stored_o(stored), .overrun_o
  );

  uart_rx_timeout #(.CT_W(CT_W)) u_tmo (
    .clk_i, .rst_ni, .flush_i(flush), .load_i(stored), .char_time_i,
    .timeout_o
  );

  assign rd_data_o = rx_en ? head : '0;
  assign empty_o   = (count == '0);
  assign full_o    = (count == CNT_W'(DEPTH));
  assign trig_o    = (32'(count) >= 32'(trig_lvl));
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              overrun_o,
  input logic              timeout_o
);
  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o)); // R1
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(full_o)); // R2
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_data_o == '0)); // R4
  AST_DISABLED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!ctrl_o[2] || ctrl_o[3]) && !ctrl_o[0]) |=> ($stable(empty_o) && $stable(full_o) && !overrun_o)); // R5
  AST_TMO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] |=> (empty_o && !full_o && !ctrl_o[0])); // R7
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DATA_W(DATA_W), .CTRL_W(uart_rx_fifo_pkg::CTRL_W)) u_chk (.*);

// File: tb/uart_rx_fifo_tb_top.sv
module uart_rx_fifo_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ctrl_wr_i = 0, mode_wr_i = 0, trig_wr_i = 0;
  logic [8:0] ctrl_wdata_i = 0;
  logic [9:0] mode_wdata_i = 0;
  logic [5:0] trig_wdata_i = 0;
  logic [15:0] char_time_i = 16'd3;
  logic line_push_i = 0, dr_wr_i = 0, dr_rd_i = 0;
  logic [7:0] line_data_i = 0, dr_wdata_i = 0;
  logic [7:0] rd_data_o;
  logic [8:0] ctrl_o;
  logic empty_o, full_o, trig_o, overrun_o, timeout_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  uart_rx_fifo dut_i (.*);

  // behavioural reference model
  logic [7:0] mq[$];
  int m_ctrl, m_mode, m_trig, m_tcnt;
  bit m_armed, m_ovr, m_tmo;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mq.delete(); m_ctrl = 'h128; m_mode = 0; m_trig = 32;
      m_tcnt = 0; m_armed = 0; m_ovr = 0; m_tmo = 0;
    end else begin
      bit en, fl, psh, was_full, stored;
      logic [7:0] pd;
      en = m_ctrl[2] && !m_ctrl[3];
      fl = m_ctrl[0];
      psh = 0; pd = line_data_i; stored = 0;
      if ((m_mode == 0 || m_mode == 1) && line_push_i) psh = en;
      if (m_mode == 2 && dr_wr_i) begin psh = en; pd = dr_wdata_i; end
      m_ovr = 0; m_tmo = 0;
      if (fl) begin
        mq.delete(); m_armed = 0; m_tcnt = 0;
      end else begin
        was_full = (mq.size() == 16);
        if (en && dr_rd_i && mq.size() > 0) void'(mq.pop_front());
        if (psh) begin
          if (was_full) m_ovr = 1;
          else begin mq.push_back(pd); stored = 1; end
        end
        if (stored) begin m_tcnt = 4 * char_time_i; m_armed = 1; end
        else if (m_armed) begin
          if (m_tcnt <= 1) begin m_armed = 0; m_tcnt = 0; m_tmo = 1; end
          else m_tcnt--;
        end
      end
      if (ctrl_wr_i) m_ctrl = ctrl_wdata_i;
      else if (fl) m_ctrl = m_ctrl & ~1;
      if (trig_wr_i) m_trig = trig_wdata_i;
      if (mode_wr_i) m_mode = mode_wdata_i[9:8];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      int exp_rd;
      exp_rd = (m_ctrl[2] && !m_ctrl[3] && mq.size() > 0) ? mq[0] : 0;
      chk("R4 model rd_data", rd_data_o, exp_rd);
      chk("R1 model empty", empty_o, mq.size() == 0);
      chk("R1 model full", full_o, mq.size() == 16);
      chk("R3 model trig", trig_o, mq.size() >= m_trig);
      chk("R2 model overrun", overrun_o, m_ovr);
      chk("R6 model timeout", timeout_o, m_tmo);
      chk("R7 model ctrl", ctrl_o, m_ctrl);
    end
  end

  task automatic step(); @(posedge clk_i); #1;
    ctrl_wr_i = 0; mode_wr_i = 0; trig_wr_i = 0;
    line_push_i = 0; dr_wr_i = 0; dr_rd_i = 0;
  endtask
  task automatic idle(input int n); repeat (n) step(); endtask
  task automatic wr_ctrl(input int v); ctrl_wr_i = 1; ctrl_wdata_i = 9'(v); step(); endtask
  task automatic set_mode(input int m); mode_wr_i = 1; mode_wdata_i = 10'(m << 8); step(); endtask
  task automatic set_trig(input int t); trig_wr_i = 1; trig_wdata_i = 6'(t); step(); endtask
  task automatic lpush(input int b); line_push_i = 1; line_data_i = 8'(b); step(); endtask
  task automatic dwrite(input int b); dr_wr_i = 1; dr_wdata_i = 8'(b); step(); endtask
  task automatic dread(); dr_rd_i = 1; step(); endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i); #1 rst_ni = 1;
    #4;
    chk("R9 ctrl after reset", ctrl_o, 'h128);
    chk("R9 empty after reset", empty_o, 1);
    chk("R3 trig low at reset level 32", trig_o, 0);
    step();
    lpush('hA5); chk("R5 push ignored while disabled", empty_o, 1);
    wr_ctrl('h104);
    lpush('h11); lpush('h22); lpush('h33);
    chk("R1 oldest first", rd_data_o, 'h11);
    set_trig(3); chk("R3 trig at level", trig_o, 1);
    dread(); chk("R3 trig below level", trig_o, 0);
    chk("R1 next byte", rd_data_o, 'h22);
    for (int i = 0; i < 14; i++) lpush('h40 + i);
    chk("R1 full at 16", full_o, 1);
    lpush('hEE); chk("R2 overrun pulse", overrun_o, 1);
    chk("R2 dropped byte not stored", rd_data_o, 'h22);
    idle(1); chk("R2 overrun one cycle", overrun_o, 0);
    line_push_i = 1; line_data_i = 8'h77; dr_rd_i = 1; step();
    chk("R2 push with pop at full dropped", overrun_o, 1);
    chk("R10 pop clears full", full_o, 0);
    for (int i = 0; i < 15; i++) dread();
    chk("R10 last pop sets empty", empty_o, 1);
    dread(); chk("R4 empty read zero", rd_data_o, 0);
    chk("R4 empty stays set", empty_o, 1);
    idle(20);
    lpush('h5A); idle(11); chk("R6 no timeout early", timeout_o, 0);
    idle(1); chk("R6 timeout after four chars", timeout_o, 1);
    idle(1); chk("R6 timeout single pulse", timeout_o, 0);
    lpush('h61); wr_ctrl('h10C);
    dread(); chk("R5 disabled reads zero", rd_data_o, 0);
    wr_ctrl('h104); chk("R5 pop ignored while disabled", rd_data_o, 'h5A);
    wr_ctrl('h105); chk("R7 flush bit set one cycle", ctrl_o[0], 1);
    idle(1); chk("R7 flush empties", empty_o, 1);
    chk("R7 flush bit self clears", ctrl_o, 'h104);
    set_mode(2); lpush('h12); chk("R8 local loop ignores line", empty_o, 1);
    dwrite('h34); chk("R8 local loop takes data write", rd_data_o, 'h34);
    dread(); set_mode(3); lpush('h56); dwrite('h57);
    chk("R8 remote loop bypasses", empty_o, 1);
    set_mode(1); lpush('h78); chk("R8 echo takes line", rd_data_o, 'h78);
    dread(); set_mode(0); dwrite('h79); chk("R8 normal ignores data write", empty_o, 1);
    set_trig(0); chk("R3 level zero trig on empty", trig_o, 1);
    idle(30);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule